// File: doc/BRIEF.md
# Flash Command Register Controller

This block is a byte-wide control register that sets up and launches operations on an on-chip flash array. Software writes a four-bit function code into the low nibble, together with a 16-bit operation address and a verify flag. The block then issues a one-cycle request that carries an operation kind and a target address. The target address is aligned to the operation's granularity: byte, 32-byte page, 256-byte block or the whole array. Write and erase operations hold a read-only high-voltage status bit at 1 for a fixed number of cycles. An internal counter sets that length, and software cannot change it.

A security input locks the function code. While the lock is on, only a write from an instruction fetched from internal program memory may change the code. The one exception is the full-erase code, which any source may load. While high voltage is present, writes to the function code are dropped. The two memory-map select bits stay writable at all times.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `hv` is 0 and `op_req` is 0. Function code 0000 starts no operation.
- R2: The register layout is: bits 7:6 are map select (read/write), bit 5 is the HV status (read-only, a written value has no effect), bit 4 is reserved and reads 0, and bits 3:0 are the function code.
- R3: Writing code 0101 with `verify_rd`=0 pulses `op_req` for one cycle on the clock after the write. It sets `op_kind`=1 (byte write) and `op_target`=`op_addr`, and holds `hv` at 1 for exactly WRITE_CYCLES cycles.
- R4: Writing code 0101 with `verify_rd`=1 pulses `op_req` with `op_kind`=2 (verify read) and `op_target`=`op_addr`. `hv` stays 0.
- R5: Code 1100 pulses `op_req` with `op_kind`=3 (page erase) and `op_target` = `op_addr` with bits 4:0 cleared. `hv` is held for PAGE_CYCLES cycles.
- R6: Code 0011 pulses `op_req` with `op_kind`=4 (block erase) and `op_target` = `op_addr` with bits 7:0 cleared. `hv` is held for BLOCK_CYCLES cycles.
- R7: Code 1010 pulses `op_req` with `op_kind`=5 (full erase) and `op_target`=0. `hv` is held for FULL_CYCLES cycles.
- R8: While `sec_lock`=1 and `fetch_internal`=0, a write whose code is not 1010 leaves the function code unchanged and starts nothing. A write with code 1010 is still accepted.
- R9: While `sec_lock`=1 and `fetch_internal`=1, function-code writes are accepted as usual.
- R10: While `hv`=1, a register write leaves the function code unchanged and produces no `op_req`, but it still updates the map select bits.
- R11: A code outside {0101, 1100, 0011, 1010} is stored and reads back, but it starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read value |
| op_addr | input | 16 | Operation address |
| verify_rd | input | 1 | Selects a verify read for the byte code |
| fetch_internal | input | 1 | Writing instruction came from internal program memory |
| sec_lock | input | 1 | Security lock active |
| op_req | output | 1 | One-cycle operation request |
| op_kind | output | 3 | Operation kind of the last request |
| op_target | output | 16 | Aligned target address of the last request |
| hv | output | 1 | High voltage present (write/erase in progress) |

## Verification
The hardest case to reach is a register write that lands while an erase is still holding high voltage. The stimulus starts a page erase and then issues a new write with a different code and different map bits on the very next cycle. The bench then confirms three things: the old code is kept, no request appears, and the map bits change. The lock exception needs its own stimulus. The bench sets the lock with an external fetch and tries a blocked code and then the full-erase code back to back, so the dropped write and the accepted write are told apart at the read port.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [3:0] FC_IDLE  = 4'b0000;
    localparam logic [3:0] FC_BYTE  = 4'b0101;
    localparam logic [3:0] FC_PAGE  = 4'b1100;
    localparam logic [3:0] FC_BLOCK = 4'b0011;
    localparam logic [3:0] FC_FULL  = 4'b1010;

    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_BYTE_WR  = 3'd1,
        OP_BYTE_RD  = 3'd2,
        OP_PAGE_ER  = 3'd3,
        OP_BLOCK_ER = 3'd4,
        OP_FULL_ER  = 3'd5
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [ADDR_W-1:0]  target;
    } op_cmd_t;

    function automatic op_kind_e code_to_kind(logic [3:0] code, logic rd);
        case (code)
            FC_BYTE:  return rd ? OP_BYTE_RD : OP_BYTE_WR;
            FC_PAGE:  return OP_PAGE_ER;
            FC_BLOCK: return OP_BLOCK_ER;
            FC_FULL:  return OP_FULL_ER;
            default:  return OP_NONE;
        endcase
    endfunction

    function automatic logic uses_hv(op_kind_e k);
        return (k != OP_NONE) && (k != OP_BYTE_RD);
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int PAGE_BITS  = 5,
    parameter int BLOCK_BITS = 8
) (
    input  logic [3:0]        code_i,
    input  logic              verify_i,
    input  logic [ADDR_W-1:0] addr_i,
    output op_cmd_t           cmd_o
);
    localparam logic [ADDR_W-1:0] PAGE_MASK  = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] BLOCK_MASK = ~((ADDR_W'(1) << BLOCK_BITS) - ADDR_W'(1));

    always_comb begin
        cmd_o.kind = code_to_kind(code_i, verify_i);
        case (cmd_o.kind)
            OP_BYTE_WR, OP_BYTE_RD: cmd_o.target = addr_i;
            OP_PAGE_ER:             cmd_o.target = addr_i & PAGE_MASK;
            OP_BLOCK_ER:            cmd_o.target = addr_i & BLOCK_MASK;
            default:                cmd_o.target = '0;
        endcase
    end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_cmd_pkg::*;
#(
    parameter int WRITE_CYCLES = 6,
    parameter int PAGE_CYCLES  = 10,
    parameter int BLOCK_CYCLES = 14,
    parameter int FULL_CYCLES  = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  op_kind_e kind_i,
    output logic     hv_o
);
    localparam int MAX_A  = (WRITE_CYCLES > PAGE_CYCLES) ? WRITE_CYCLES : PAGE_CYCLES;
    localparam int MAX_B  = (BLOCK_CYCLES > FULL_CYCLES) ? BLOCK_CYCLES : FULL_CYCLES;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        case (kind_i)
            OP_PAGE_ER:  load_val = CNT_W'(PAGE_CYCLES - 1);
            OP_BLOCK_ER: load_val = CNT_W'(BLOCK_CYCLES - 1);
            OP_FULL_ER:  load_val = CNT_W'(FULL_CYCLES - 1);
            default:     load_val = CNT_W'(WRITE_CYCLES - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hv_o  <= 1'b0;
            cnt_q <= '0;
        end else if (start_i && !hv_o && uses_hv(kind_i)) begin
            hv_o  <= 1'b1;
            cnt_q <= load_val;
        end else if (hv_o) begin
            if (cnt_q == '0) hv_o <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R3, R5, R6, R7: high voltage drops only after the count has run out
    a_r3_hv_runs_out: assert property (@(posedge clk) disable iff (rst)
        $fell(hv_o) |-> $past(cnt_q) == '0);

    // R10: a running operation is not reloaded by the count
    a_r10_no_reload: assert property (@(posedge clk) disable iff (rst)
        (hv_o && cnt_q != '0) |=> (hv_o && cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int WRITE_CYCLES = 6,
    parameter int PAGE_CYCLES  = 10,
    parameter int BLOCK_CYCLES = 14,
    parameter int FULL_CYCLES  = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wr_data,
    output logic [7:0]  reg_rd_data,
    input  logic [15:0] op_addr,
    input  logic        verify_rd,
    input  logic        fetch_internal,
    input  logic        sec_lock,
    output logic        op_req,
    output logic [2:0]  op_kind,
    output logic [15:0] op_target,
    output logic        hv
);
    logic [1:0] map_q;
    logic [3:0] fcode_q;
    op_cmd_t    dec_cmd;
    op_cmd_t    cmd_q;
    logic       code_ok;
    logic       start;
    logic       unused_bits;

    assign unused_bits = ^reg_wr_data[5:4];

    flash_cmd_decode #(
        .PAGE_BITS  (5),
        .BLOCK_BITS (8)
    ) decode_i (
        .code_i   (reg_wr_data[3:0]),
        .verify_i (verify_rd),
        .addr_i   (op_addr),
        .cmd_o    (dec_cmd)
    );

    assign code_ok = reg_wr_en && !hv &&
                     (!sec_lock || fetch_internal || reg_wr_data[3:0] == FC_FULL);
    assign start   = code_ok && (dec_cmd.kind != OP_NONE);

    flash_op_timer #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .PAGE_CYCLES  (PAGE_CYCLES),
        .BLOCK_CYCLES (BLOCK_CYCLES),
        .FULL_CYCLES  (FULL_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .kind_i  (dec_cmd.kind),
        .hv_o    (hv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q   <= 2'b00;
            fcode_q <= FC_IDLE;
            op_req  <= 1'b0;
            cmd_q   <= '{kind: OP_NONE, target: '0};
        end else begin
            op_req <= start;
            if (reg_wr_en) map_q   <= reg_wr_data[7:6];
            if (code_ok)   fcode_q <= reg_wr_data[3:0];
            if (start)     cmd_q   <= dec_cmd;
        end
    end

    assign reg_rd_data = {map_q, hv, 1'b0, fcode_q};
    assign op_kind     = cmd_q.kind;
    assign op_target   = cmd_q.target;

    // R1: a request always follows a register write
    a_r1_req_from_write: assert property (@(posedge clk) disable iff (rst)
        op_req |-> $past(reg_wr_en));

    // R10: no request is issued for a write made during high voltage
    a_r10_busy_drop: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && hv) |=> !op_req);

    // R8: a locked external write of a non-full code starts nothing
    a_r8_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && sec_lock && !fetch_internal && reg_wr_data[3:0] != FC_FULL)
        |=> (!op_req && reg_rd_data[3:0] == $past(reg_rd_data[3:0])));

    // R4: a verify read never raises high voltage
    a_r4_read_no_hv: assert property (@(posedge clk) disable iff (rst)
        (op_req && op_kind == OP_BYTE_RD) |-> !hv);

    // R6: a block target is 256-byte aligned
    a_r6_block_align: assert property (@(posedge clk) disable iff (rst)
        (op_req && op_kind == OP_BLOCK_ER) |-> op_target[7:0] == 8'h00);

    // R7: a full erase targets address zero
    a_r7_full_zero: assert property (@(posedge clk) disable iff (rst)
        (op_req && op_kind == OP_FULL_ER) |-> op_target == 16'h0000);

    // R2: reserved bit always reads zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[4] == 1'b0);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
    localparam int WRC = 6;
    localparam int PGC = 10;
    localparam int BKC = 14;
    localparam int FLC = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_data;
    logic [7:0]  reg_rd_data;
    logic [15:0] op_addr;
    logic        verify_rd;
    logic        fetch_internal;
    logic        sec_lock;
    logic        op_req;
    logic [2:0]  op_kind;
    logic [15:0] op_target;
    logic        hv;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(
        .WRITE_CYCLES (WRC),
        .PAGE_CYCLES  (PGC),
        .BLOCK_CYCLES (BKC),
        .FULL_CYCLES  (FLC)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .reg_wr_en      (reg_wr_en),
        .reg_wr_data    (reg_wr_data),
        .reg_rd_data    (reg_rd_data),
        .op_addr        (op_addr),
        .verify_rd      (verify_rd),
        .fetch_internal (fetch_internal),
        .sec_lock       (sec_lock),
        .op_req         (op_req),
        .op_kind        (op_kind),
        .op_target      (op_target),
        .hv             (hv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive one write on a negedge; returns at the next negedge, after the capturing edge
    task automatic wr(input logic [7:0] d, input logic [15:0] a, input logic vr);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        op_addr     = a;
        verify_rd   = vr;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic hv_len(output int n);
        n = 0;
        while (hv && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (hv) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rd", {24'h0, reg_rd_data}, 32'h00);
        check("R1 hv", {31'h0, hv}, 32'h0);
        check("R1 req", {31'h0, op_req}, 32'h0);
    endtask

    task automatic t_layout();
        wr(8'hF0, 16'h1234, 1'b0);
        check("R2 rd", {24'h0, reg_rd_data}, 32'hC0);
        check("R1 idle code no req", {31'h0, op_req}, 32'h0);
        check("R1 idle code no hv", {31'h0, hv}, 32'h0);
        wr(8'h10, 16'h1234, 1'b0);
        check("R2 reserved", {24'h0, reg_rd_data}, 32'h00);
    endtask

    task automatic t_byte_write();
        int n;
        wr(8'h05, 16'hA5F7, 1'b0);
        check("R3 req", {31'h0, op_req}, 32'h1);
        check("R3 kind", {29'h0, op_kind}, 32'd1);
        check("R3 target", {16'h0, op_target}, 32'hA5F7);
        check("R2 hv bit", {31'h0, reg_rd_data[5]}, 32'h1);
        @(negedge clk);
        check("R3 req one cycle", {31'h0, op_req}, 32'h0);
        hv_len(n);
        check("R3 hv length", n, WRC - 1);
        wait_idle();
    endtask

    task automatic t_verify();
        wr(8'h05, 16'h3C21, 1'b1);
        check("R4 req", {31'h0, op_req}, 32'h1);
        check("R4 kind", {29'h0, op_kind}, 32'd2);
        check("R4 target", {16'h0, op_target}, 32'h3C21);
        check("R4 hv", {31'h0, hv}, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_page();
        int n;
        wr(8'h0C, 16'hA5F7, 1'b0);
        check("R5 kind", {29'h0, op_kind}, 32'd3);
        check("R5 target", {16'h0, op_target}, 32'hA5E0);
        hv_len(n);
        check("R5 hv length", n, PGC);
        wait_idle();
    endtask

    task automatic t_block();
        int n;
        wr(8'h03, 16'hA5F7, 1'b0);
        check("R6 kind", {29'h0, op_kind}, 32'd4);
        check("R6 target", {16'h0, op_target}, 32'hA500);
        hv_len(n);
        check("R6 hv length", n, BKC);
        wait_idle();
    endtask

    task automatic t_full();
        int n;
        wr(8'h0A, 16'hFFFF, 1'b0);
        check("R7 kind", {29'h0, op_kind}, 32'd5);
        check("R7 target", {16'h0, op_target}, 32'h0000);
        hv_len(n);
        check("R7 hv length", n, FLC);
        wait_idle();
    endtask

    task automatic t_invalid();
        wr(8'h06, 16'h0001, 1'b0);
        check("R11 stored", {24'h0, reg_rd_data}, 32'h06);
        check("R11 no req", {31'h0, op_req}, 32'h0);
        check("R11 no hv", {31'h0, hv}, 32'h0);
    endtask

    task automatic t_lock();
        sec_lock = 1'b1;
        fetch_internal = 1'b0;
        wr(8'h0C, 16'h4444, 1'b0);
        check("R8 blocked code", {28'h0, reg_rd_data[3:0]}, 32'h6);
        check("R8 blocked req", {31'h0, op_req}, 32'h0);
        wr(8'h0A, 16'h4444, 1'b0);
        check("R8 full allowed", {31'h0, op_req}, 32'h1);
        check("R8 full kind", {29'h0, op_kind}, 32'd5);
        wait_idle();
        fetch_internal = 1'b1;
        wr(8'h03, 16'h12FF, 1'b0);
        check("R9 internal req", {31'h0, op_req}, 32'h1);
        check("R9 internal target", {16'h0, op_target}, 32'h1200);
        wait_idle();
        sec_lock = 1'b0;
        fetch_internal = 1'b0;
    endtask

    task automatic t_busy();
        wr(8'h0C, 16'h0040, 1'b0);
        wr(8'h85, 16'h0041, 1'b0);
        check("R10 no req", {31'h0, op_req}, 32'h0);
        check("R10 code kept", {28'h0, reg_rd_data[3:0]}, 32'hC);
        check("R10 map updated", {30'h0, reg_rd_data[7:6]}, 32'h2);
        check("R10 kind kept", {29'h0, op_kind}, 32'd3);
        wait_idle();
    endtask

    initial begin
        rst = 1'b1;
        reg_wr_en = 1'b0;
        reg_wr_data = 8'h00;
        op_addr = 16'h0;
        verify_rd = 1'b0;
        fetch_internal = 1'b0;
        sec_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_byte_write();
        t_verify();
        t_page();
        t_block();
        t_full();
        t_invalid();
        t_lock();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule